// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from up to fifteen peripherals and reduces them to one interrupt line toward the processor. It is made of two identical eight-input stages. The interrupt output of the secondary stage feeds input 2 of the primary stage. Requests on lines 0–7 reach the primary stage, and requests on lines 8–15 reach secondary inputs 0–7. Line 2 itself is not usable. A peripheral that older software expects on line 2 is wired to line 9 instead.

Requests are sampled once per cycle, and the pending request with the highest priority is selected. The processor line is then raised, and the block waits for an acknowledge pulse. When the pulse arrives, the block records the winner in the in-service register of each stage involved and presents an 8-bit vector on the next cycle. The vector is a 5-bit per-stage base followed by the 3-bit input index. A small write port loads the two bases and issues a per-stage end-of-interrupt. An end-of-interrupt clears the highest-priority in-service bit of that stage. A request of higher priority than the one in service can interrupt it. A request of equal or lower priority must wait.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, cpuIrq and vecValid are low and both in-service registers are clear. The primary base resets to 5'h01, giving vectors 0x08+index. The secondary base resets to 5'h0E, giving vectors 0x70+index.
- R2: A request line is sampled on each clock edge. cpuIrq is high in the cycle after the edge that samples a serviceable request. With no request present, cpuIrq stays low.
- R3: Priority is fixed, and a lower line number wins. All secondary lines 8–15 together rank at the position of primary input 2, which is below lines 0 and 1 and above lines 3–7.
- R4: An intAck pulse sampled while cpuIrq is high makes vecValid high for exactly one cycle, starting after that edge. In that cycle vecOut is {base, index}. A primary winner uses the primary base and its line number. A secondary winner uses the secondary base and the line number minus 8.
- R5: irqLines[2] has no effect. The device on line 9 is serviced with vector {secondary base, 3'd1}.
- R6: An acknowledge sets the in-service bit of the winning input. A request whose priority is equal to or lower than the highest set in-service bit of its stage keeps cpuIrq low. A request of strictly higher priority raises cpuIrq and can be acknowledged (nesting).
- R7: A write to address 2 clears the highest-priority set in-service bit of the primary stage. A write to address 3 does the same for the secondary stage. A source on the secondary stage needs both writes before a lower-priority secondary request is serviced.
- R8: Requests are level-sensitive. If a request drops before acknowledge, an intAck produces no vecValid and sets no in-service bit.
- R9: A write to address 0 loads the primary base from regWdata[7:3]. A write to address 1 loads the secondary base from regWdata[7:3].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 16 | Level request lines; bit 2 is unused |
| intAck | input | 1 | Acknowledge pulse from the processor |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 primary base, 1 secondary base, 2 primary EOI, 3 secondary EOI |
| regWdata | input | 8 | Write data; bits 7:3 carry a base |
| cpuIrq | output | 1 | Interrupt line to the processor |
| vecOut | output | 8 | Vector of the acknowledged source |
| vecValid | output | 1 | vecOut is valid this cycle |

## Verification
The assertions assume that intAck is a single-cycle pulse, and that an acknowledge is only meaningful while cpuIrq is high. An acknowledge at any other time must leave all state unchanged. They also assume that one register write carries at most one end-of-interrupt per stage. The directed stimulus changes every input on the falling edge and holds intAck and regWe for exactly one cycle. It issues the end-of-interrupt writes that each acknowledged source needs before the next scenario starts.

// File: rtl/pic_pkg.sv
package pic_pkg;
  parameter int STAGE_LINES = 8;
  parameter int IDX_W       = $clog2(STAGE_LINES);
  parameter int VEC_W       = 8;
  parameter int BASE_W      = VEC_W - IDX_W;
  parameter int CASC_LINE   = 2;
  parameter int ALL_LINES   = 2 * STAGE_LINES;

  typedef enum logic [1:0] {
    SEL_PRI_BASE = 2'd0,
    SEL_SEC_BASE = 2'd1,
    SEL_PRI_EOI  = 2'd2,
    SEL_SEC_EOI  = 2'd3
  } regSel_t;

  typedef struct packed {
    logic ackSet;
    logic eoi;
    logic baseWr;
  } stageStrobe_t;
endpackage

// File: rtl/pic_stage_dp.sv
module pic_stage_dp
  import pic_pkg::*;
#(
  parameter int LINES    = STAGE_LINES,
  parameter int IW       = $clog2(LINES),
  parameter int BW       = BASE_W,
  parameter bit CASCADED = 1'b0,
  parameter int CPOS     = CASC_LINE,
  parameter logic [BW-1:0] BASE_RST = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] reqIn,
  input  logic             cascIn,
  input  stageStrobe_t     strb,
  input  logic [BW-1:0]    baseData,
  output logic             intOut,
  output logic [IW-1:0]    winIdx,
  output logic [BW-1:0]    base
);
  localparam logic [LINES-1:0] ONE = {{(LINES-1){1'b0}}, 1'b1};

  logic [LINES-1:0] irr, reqEff, isr, isrNext;
  logic [IW-1:0]    isrTop;
  logic             reqAny, isrAny;

  function automatic logic [IW-1:0] lowIdx(input logic [LINES-1:0] v);
    lowIdx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) lowIdx = i[IW-1:0];
  endfunction

  generate
    if (CASCADED) begin : g_casc
      localparam logic [LINES-1:0] CMASK = ONE << CPOS;
      always_ff @(posedge clk) begin
        if (!rstN) irr <= '0;
        else       irr <= reqIn & ~CMASK;
      end
      assign reqEff = irr | (cascIn ? CMASK : '0);
    end else begin : g_plain
      wire unusedCasc = cascIn;
      always_ff @(posedge clk) begin
        if (!rstN) irr <= '0;
        else       irr <= reqIn;
      end
      assign reqEff = irr;
    end
  endgenerate

  assign reqAny = |reqEff;
  assign isrAny = |isr;
  assign winIdx = lowIdx(reqEff);
  assign isrTop = lowIdx(isr);
  assign intOut = reqAny && (!isrAny || (winIdx < isrTop));

  always_comb begin
    isrNext = isr;
    if (strb.eoi && isrAny) isrNext[isrTop] = 1'b0;
    if (strb.ackSet)        isrNext[winIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isr  <= '0;
      base <= BASE_RST;
    end else begin
      isr <= isrNext;
      if (strb.baseWr) base <= baseData;
    end
  end

  // R6: in-service bits appear only through an acknowledge strobe
  a_r6_isr_only_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ackSet |=> ((isr & ~$past(isr)) == '0));
  // R6/R8: control acknowledges this stage only while it is requesting
  a_r8_ack_needs_int: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackSet |-> intOut);
  // R7: a lone EOI removes exactly one in-service bit
  a_r7_eoi_clears_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && !strb.ackSet && isrAny) |=>
      ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               intAck,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [VEC_W-1:0]   regWdata,
  input  logic               priInt,
  input  logic [IDX_W-1:0]   priWin,
  input  logic [IDX_W-1:0]   secWin,
  input  logic [BASE_W-1:0]  priBase,
  input  logic [BASE_W-1:0]  secBase,
  output stageStrobe_t       priStrb,
  output stageStrobe_t       secStrb,
  output logic [BASE_W-1:0]  baseData,
  output logic [VEC_W-1:0]   vecOut,
  output logic               vecValid
);
  localparam logic [IDX_W-1:0] CIDX = IDX_W'(CASC_LINE);

  logic    ackOk, viaSec;
  regSel_t sel;
  wire     unusedLow = ^regWdata[IDX_W-1:0];

  assign sel      = regSel_t'(regAddr);
  assign ackOk    = intAck && priInt;
  assign viaSec   = (priWin == CIDX);
  assign baseData = regWdata[VEC_W-1:IDX_W];

  always_comb begin
    priStrb.ackSet = ackOk;
    secStrb.ackSet = ackOk && viaSec;
    priStrb.eoi    = regWe && (sel == SEL_PRI_EOI);
    secStrb.eoi    = regWe && (sel == SEL_SEC_EOI);
    priStrb.baseWr = regWe && (sel == SEL_PRI_BASE);
    secStrb.baseWr = regWe && (sel == SEL_SEC_BASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      vecValid <= ackOk;
      if (ackOk) vecOut <= viaSec ? {secBase, secWin} : {priBase, priWin};
    end
  end

  // R4: a vector is presented only after an acknowledge edge
  a_r4_vec_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(intAck));
  // R4: with single-cycle acknowledge pulses the vector lasts one cycle
  a_r4_vec_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !intAck) |=> !vecValid);
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ALL_LINES-1:0] irqLines,
  input  logic                 intAck,
  input  logic                 regWe,
  input  logic [1:0]           regAddr,
  input  logic [VEC_W-1:0]     regWdata,
  output logic                 cpuIrq,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  stageStrobe_t        priStrb, secStrb;
  logic [BASE_W-1:0]   baseData, priBase, secBase;
  logic [IDX_W-1:0]    priWin, secWin;
  logic                priInt, secInt;

  pic_stage_dp #(.CASCADED(1'b1), .BASE_RST(BASE_W'(1))) i_pri (
    .clk(clk), .rstN(rstN), .reqIn(irqLines[STAGE_LINES-1:0]), .cascIn(secInt),
    .strb(priStrb), .baseData(baseData), .intOut(priInt), .winIdx(priWin),
    .base(priBase));

  pic_stage_dp #(.CASCADED(1'b0), .BASE_RST(BASE_W'(14))) i_sec (
    .clk(clk), .rstN(rstN), .reqIn(irqLines[ALL_LINES-1:STAGE_LINES]),
    .cascIn(1'b0), .strb(secStrb), .baseData(baseData), .intOut(secInt),
    .winIdx(secWin), .base(secBase));

  pic_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .intAck(intAck), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .priInt(priInt), .priWin(priWin), .secWin(secWin),
    .priBase(priBase), .secBase(secBase), .priStrb(priStrb), .secStrb(secStrb),
    .baseData(baseData), .vecOut(vecOut), .vecValid(vecValid));

  assign cpuIrq = priInt;

  // R2: the processor line is never raised in the cycle after reset releases
  a_r2_quiet_after_reset: assert property (@(posedge clk)
    !rstN |=> !cpuIrq);
endmodule

// File: tb/test_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module test_irq_cascade_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqLines = '0;
  logic        intAck = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic        cpuIrq, vecValid;
  logic [7:0]  vecOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_cascade_ctrl i_irq_cascade_ctrl (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .intAck(intAck), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .cpuIrq(cpuIrq), .vecOut(vecOut),
    .vecValid(vecValid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic ackVec(output logic v, output logic [7:0] vec);
    @(negedge clk) intAck = 1'b1;
    @(negedge clk) intAck = 1'b0;
    v = vecValid; vec = vecOut;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk) begin regWe = 1'b1; regAddr = a; regWdata = d; end
    @(negedge clk) regWe = 1'b0;
  endtask

  task automatic expectVec(input string req, input logic [7:0] exp);
    logic v; logic [7:0] vec;
    ackVec(v, vec);
    chk(v == 1'b1, req, v, 1);
    chk(vec == exp, req, vec, exp);
  endtask

  task automatic t_reset();
    logic v; logic [7:0] vec;
    chk(cpuIrq == 1'b0, "R1 irq", cpuIrq, 0);
    chk(vecValid == 1'b0, "R1 valid", vecValid, 0);
    ackVec(v, vec);
    chk(v == 1'b0, "R1 ack idle", v, 0);
  endtask

  task automatic t_basic();
    irqLines[5] = 1'b1; tick();
    chk(cpuIrq == 1'b1, "R2 raise", cpuIrq, 1);
    expectVec("R4 vec line5", 8'h0D);
    tick();
    chk(vecValid == 1'b0, "R4 one cycle", vecValid, 0);
    chk(cpuIrq == 1'b0, "R6 same held", cpuIrq, 1'b0);
    irqLines = '0; wr(2, 0); tick();
    chk(cpuIrq == 1'b0, "R2 no request", cpuIrq, 0);
  endtask

  task automatic t_priority();
    irqLines[12] = 1'b1; irqLines[3] = 1'b1; tick();
    expectVec("R3 sec over 3", 8'h74);
    chk(cpuIrq == 1'b0, "R6 line3 blocked", cpuIrq, 0);
    irqLines[12] = 1'b0; wr(3, 0); wr(2, 0); tick();
    chk(cpuIrq == 1'b1, "R3 line3 now", cpuIrq, 1);
    expectVec("R3 line3 vec", 8'h0B);
    irqLines = '0; wr(2, 0);
    irqLines[1] = 1'b1; irqLines[8] = 1'b1; tick();
    expectVec("R3 line1 over sec", 8'h09);
    irqLines = '0; wr(2, 0); tick();
  endtask

  task automatic t_line2();
    logic v; logic [7:0] vec;
    irqLines[2] = 1'b1; tick(); tick();
    chk(cpuIrq == 1'b0, "R5 line2 ignored", cpuIrq, 0);
    ackVec(v, vec);
    chk(v == 1'b0, "R5 line2 no vec", v, 0);
    irqLines = '0; irqLines[9] = 1'b1; tick();
    expectVec("R5 line9 vec", 8'h71);
    irqLines = '0; wr(3, 0); wr(2, 0); tick();
  endtask

  task automatic t_preempt();
    irqLines[6] = 1'b1; tick();
    expectVec("R6 line6", 8'h0E);
    chk(cpuIrq == 1'b0, "R6 equal waits", cpuIrq, 0);
    irqLines[4] = 1'b1; tick();
    chk(cpuIrq == 1'b1, "R6 higher preempts", cpuIrq, 1);
    expectVec("R6 nested line4", 8'h0C);
    irqLines = '0; irqLines[7] = 1'b1; tick();
    chk(cpuIrq == 1'b0, "R6 lower waits", cpuIrq, 0);
    wr(2, 0); tick();
    chk(cpuIrq == 1'b0, "R7 still under 6", cpuIrq, 0);
    wr(2, 0); tick();
    chk(cpuIrq == 1'b1, "R7 line7 free", cpuIrq, 1);
    expectVec("R6 line7 vec", 8'h0F);
    irqLines = '0; wr(2, 0); tick();
  endtask

  task automatic t_cascadeEoi();
    irqLines[10] = 1'b1; tick();
    expectVec("R7 line10", 8'h72);
    irqLines = '0; irqLines[11] = 1'b1;
    wr(2, 0); tick();
    chk(cpuIrq == 1'b0, "R7 needs sec eoi", cpuIrq, 0);
    wr(3, 0); tick();
    chk(cpuIrq == 1'b1, "R7 both eoi", cpuIrq, 1);
    expectVec("R7 line11", 8'h73);
    irqLines = '0; wr(3, 0); wr(2, 0); tick();
  endtask

  task automatic t_level();
    logic v; logic [7:0] vec;
    irqLines[0] = 1'b1; tick();
    chk(cpuIrq == 1'b1, "R8 raised", cpuIrq, 1);
    irqLines[0] = 1'b0; tick();
    chk(cpuIrq == 1'b0, "R8 dropped", cpuIrq, 0);
    ackVec(v, vec);
    chk(v == 1'b0, "R8 no vec", v, 0);
    irqLines[5] = 1'b1; tick();
    chk(cpuIrq == 1'b1, "R8 no isr left", cpuIrq, 1);
    expectVec("R8 line5 after", 8'h0D);
    irqLines = '0; wr(2, 0); tick();
  endtask

  task automatic t_base();
    wr(0, 8'h40); wr(1, 8'hA0);
    irqLines[5] = 1'b1; tick();
    expectVec("R9 pri base", 8'h45);
    irqLines = '0; wr(2, 0);
    irqLines[13] = 1'b1; tick();
    expectVec("R9 sec base", 8'hA5);
    irqLines = '0; wr(3, 0); wr(2, 0); tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_priority();
    t_line2();
    t_preempt();
    t_cascadeEoi();
    t_level();
    t_base();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule